// File: doc/BRIEF.md
# Two-of-Last-Three Serial Detector

The block watches a 1-bit serial stream and flags each accepted bit that completes a three-bit window containing exactly two ones. The window always includes the bit being presented, so the flag is a Mealy output: it depends on the stored history and on the current input bit, and it appears in the same cycle as that bit. The block counts ones inside a sliding window. It does not match a fixed bit pattern, so 011, 101 and 110 all give a hit, while 111, 001, 010, 100 and 000 do not.

The history is held in a seven-state machine. There is a start state and two warm-up states that remember a single bit. The other four states remember the two most recent bits. Until three bits have been accepted after reset, the output stays low. The upstream side offers a bit by raising `bit_valid`. The block has no ready signal and never applies back-pressure: it takes every bit offered on a rising clock edge. Cycles with `bit_valid` low are not part of the stream. They leave the history as it is and keep the output low.

Top module: `tlt_detector`

## Requirements
- R1: After a synchronous active-high reset, the first two bits accepted always give `detect` = 0, whatever their values.
- R2: In any cycle with `bit_valid` low, `detect` is 0.
- R3: A cycle with `bit_valid` low does not change the stored history. The outputs for a bit stream are the same whether or not idle cycles are placed between its bits.
- R4: From the third accepted bit onward, `detect` equals 1 exactly when the current `bit_in` plus the two previously accepted bits hold exactly two ones.
- R5: A window of three ones gives 0, so a steady run of ones holds `detect` at 0 once warm-up is over. A window with a single one gives 0.
- R6: The accepted bits 0,1,1,0,1,1,1,0,0 give the output sequence 0,0,1,1,1,1,0,1,0.
- R7: A reset in the middle of a stream discards the history, and the warm-up of R1 applies again.
- R8: After a long run of zeros the machine stays in its all-zero history with output 0. A following 1,1 gives 0 on the first one and 1 on the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_valid | input | 1 | High when `bit_in` carries a stream bit this cycle |
| bit_in | input | 1 | Serial data bit |
| detect | output | 1 | Combinational Mealy flag for the bit currently offered |

## Verification
The assertions assume that `bit_in` is a known value whenever `bit_valid` is high. They also assume that reset is held across the first clock edge, so the checker's own warm-up counter and history start in step with the design. The bench keeps to both assumptions: it holds reset from time zero, and it drives every input one nanosecond after a rising edge, with data always defined. Idle gaps, mid-stream resets and a long pseudo-random stream all exercise the history at the points the assertions watch.

// File: rtl/tlt_pkg.sv
package tlt_pkg;
  localparam int STATE_W = 3;

  // Encoding of the history states. The numeric values are fixed.
  typedef enum logic [STATE_W-1:0] {
    ST_START = 3'b000,
    ST_ONE0  = 3'b001,
    ST_ONE1  = 3'b010,
    ST_H00   = 3'b011,
    ST_H01   = 3'b100,
    ST_H10   = 3'b101,
    ST_H11   = 3'b110,
    ST_BAD   = 3'b111
  } tlt_state_e;
endpackage

// File: rtl/tlt_next.sv
module tlt_next
  import tlt_pkg::*;
(
  input  tlt_state_e cur,
  input  logic       din,
  output tlt_state_e nxt
);
  always_comb begin
    case (cur)
      ST_START: nxt = din ? ST_ONE1 : ST_ONE0;
      ST_ONE0:  nxt = din ? ST_H01  : ST_H00;
      ST_ONE1:  nxt = din ? ST_H11  : ST_H10;
      ST_H00:   nxt = din ? ST_H01  : ST_H00;
      ST_H01:   nxt = din ? ST_H11  : ST_H10;
      ST_H10:   nxt = din ? ST_H01  : ST_H00;
      ST_H11:   nxt = din ? ST_H11  : ST_H10;
      default:  nxt = ST_START;   // unused code falls back to start
    endcase
  end
endmodule

// File: rtl/tlt_hit.sv
module tlt_hit
  import tlt_pkg::*;
(
  input  tlt_state_e cur,
  input  logic       din,
  output logic       hit
);
  // Only the full-history states can complete a window.
  always_comb begin
    case (cur)
      ST_H01:  hit = din;
      ST_H10:  hit = din;
      ST_H11:  hit = ~din;
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/tlt_state_reg.sv
module tlt_state_reg
  import tlt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       adv,
  input  tlt_state_e d,
  output tlt_state_e q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= ST_START;
    else if (adv) q <= d;
  end
endmodule

// File: rtl/tlt_detector.sv
module tlt_detector
  import tlt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bit_valid,
  input  logic bit_in,
  output logic detect
);
  tlt_state_e state_q;
  tlt_state_e state_d;
  logic       raw_hit;

  tlt_next u_next (
    .cur (state_q),
    .din (bit_in),
    .nxt (state_d)
  );

  tlt_hit u_hit (
    .cur (state_q),
    .din (bit_in),
    .hit (raw_hit)
  );

  tlt_state_reg u_reg (
    .clk (clk),
    .rst (rst),
    .adv (bit_valid),
    .d   (state_d),
    .q   (state_q)
  );

  assign detect = bit_valid & raw_hit;
endmodule

// File: rtl/tlt_detector_chk.sv
module tlt_detector_chk
  import tlt_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       bit_valid,
  input logic       bit_in,
  input logic       detect,
  input tlt_state_e state
);
  logic [1:0] seen_q;
  logic [1:0] win_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q <= 2'd0;
      win_q  <= 2'b00;
    end else if (bit_valid) begin
      if (seen_q != 2'd2) seen_q <= seen_q + 2'd1;
      win_q <= {win_q[0], bit_in};
    end
  end

  AST_WARMUP_QUIET: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && seen_q != 2'd2) |-> !detect); // R1

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !bit_valid |-> !detect); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bit_valid |=> $stable(state)); // R3

  AST_WINDOW_COUNT: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && seen_q == 2'd2) |->
      (detect == ($countones({win_q, bit_in}) == 2))); // R4

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    state != ST_BAD); // R4
endmodule

bind tlt_detector tlt_detector_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .bit_valid (bit_valid),
  .bit_in    (bit_in),
  .detect    (detect),
  .state     (state_q)
);

// File: tb/tb_tlt_detector.sv
`timescale 1ns/1ps
module tb_tlt_detector;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_valid = 1'b0;
  logic bit_in = 1'b0;
  logic detect;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  bit    exp_q[$];
  string tag_q[$];

  // Bench model of the stream history
  int   seen = 0;
  logic h1 = 1'b0;
  logic h0 = 1'b0;

  always #2.5 clk = ~clk;

  tlt_detector dut (
    .clk       (clk),
    .rst       (rst),
    .bit_valid (bit_valid),
    .bit_in    (bit_in),
    .detect    (detect)
  );

  task automatic do_reset();
    @(posedge clk); #1;
    rst = 1'b1; bit_valid = 1'b0;
    @(posedge clk); #1;
    rst = 1'b0;
    seen = 0; h1 = 1'b0; h0 = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      bit_valid = 1'b0;
      bit_in = ~bit_in;
    end
  endtask

  // Driver: offers one bit and pushes the expected flag
  task automatic send(input logic b, input string tag);
    bit e;
    @(posedge clk); #1;
    bit_valid = 1'b1;
    bit_in = b;
    if (seen < 2) e = 1'b0;
    else e = ((int'(h1) + int'(h0) + int'(b)) == 2);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    h1 = h0; h0 = b;
    if (seen < 2) seen++;
  endtask

  task automatic send_vec(input logic [15:0] v, input int n, input string tag);
    for (int i = n - 1; i >= 0; i--) send(v[i], tag);
  endtask

  // Monitor: compares away from the rising edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (bit_valid) begin
        if (exp_q.size() == 0) begin
          checks++; failures++;
          $display("FAIL scoreboard empty: actual=%0b expected=none", detect);
        end else begin
          bit    e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          checks++;
          if (detect !== e) begin
            failures++;
            $display("FAIL %s: detect actual=%0b expected=%0b", t, detect, e);
          end
        end
      end else begin
        checks++;
        if (detect !== 1'b0) begin
          failures++;
          $display("FAIL R2: idle detect actual=%0b expected=0", detect);
        end
      end
    end
  end

  initial begin
    #1000000;
    if (!finished) begin
      finished = 1'b1;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] lfsr;
    do_reset();

    // R1: warm-up ones give 0, reset state behaviour
    send(1'b1, "R1"); send(1'b1, "R1"); send(1'b0, "R1");

    // R6: reference stream
    do_reset();
    send_vec(16'b0000000_011011100, 9, "R6");

    // R3: same stream with idle gaps between bits
    do_reset();
    for (int i = 8; i >= 0; i--) begin
      send(9'b011011100 >> i, "R3");
      idle(i % 3);
    end

    // R5: runs of ones and isolated ones
    do_reset();
    send_vec(16'h00FF, 8, "R5");
    send_vec(16'b0000000_100100100, 9, "R5");

    // R8: long zeros then 1,1
    do_reset();
    for (int i = 0; i < 20; i++) send(1'b0, "R8");
    send(1'b1, "R8"); send(1'b1, "R8");

    // R7: reset mid-stream restarts warm-up
    send(1'b0, "R7");
    do_reset();
    send(1'b0, "R7"); send(1'b1, "R7"); send(1'b1, "R7"); send(1'b0, "R7");

    // R4: pseudo-random stream with random gaps
    do_reset();
    lfsr = 8'hA5;
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      send(lfsr[0], "R4");
      if (lfsr[7] & lfsr[6]) idle(1);
    end

    idle(3);
    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R4: pending actual=%0d expected=0", exp_q.size());
    end
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule